// File: doc/BRIEF.md
# Periodic Reload Down-Counter

This block is a single-channel timer that counts down from a 16-bit reload value. It counts once for each pulse on a tick-enable input, which nominally runs at 1 MHz. When the counter is at zero and a tick arrives while the timer is enabled, the counter reloads and the block raises a one-cycle expiry pulse. The interrupt logic outside the block uses that pulse. The tick rate is set outside the block, and there is no prescaler or frequency selection inside it.

Software reaches the timer through a 256-byte register window and may use 32-bit accesses only. The window has three registers:

- **Control** at 0x00. Bit 31 is a self-clear command and bit 0 is the run enable.
- **Reload** at 0x08.
- **Count** at 0x0C, which is read-only.

The block accepts every request in the cycle it is presented, so there is no back-pressure on requests. A read answers exactly one cycle later with a one-cycle valid strobe. The response cannot be stalled, so the requester must take it in that cycle.

Top module: `rtick_timer`

## Requirements
- R1: After reset, all three registers read zero and the expiry pulse is low.
- R2: A request is honoured only when the size code is 2'b10 (four bytes). A write with any other size code changes nothing. A read with any other size code returns zero.
- R3: A write to offset 0x08 keeps bits [15:0] of the data as the reload value and loads the counter with that value at once. Offset 0x08 reads back the reload value with bits [31:16] as zero.
- R4: A control write with bit 31 clear stores the whole 32-bit word. Offset 0x00 reads that word back. Bit 0 of the stored word enables counting.
- R5: A control write with bit 31 set clears control, the reload value and the counter to zero, which stops the timer. No other bit of that write is stored.
- R6: While the timer is enabled, each tick decrements a non-zero counter by one. A tick that finds the counter at zero reloads it from the reload value instead, and `expired` is high for exactly the following cycle.
- R7: While enable is clear, the counter holds its value whatever the tick input does.
- R8: Offset 0x0C reads the live counter with bits [31:16] as zero. Writes to offset 0x0C have no effect.
- R9: Offsets other than 0x00, 0x08 and 0x0C read zero, and writes to them have no effect.
- R10: `rsp_valid` is high in the cycle after each read request. `rsp_rdata` reflects the register state before any update made in the cycle of the request.
- R11: A reload write or a self-clear write in the same cycle as a tick takes precedence over the tick. The counter takes the written value or zero, and no expiry pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one cycle per timer tick |
| req_valid | input | 1 | Register request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the window |
| req_size | input | 2 | Access size code; 2'b10 = four bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 32 | Read response data |
| expired | output | 1 | One-cycle pulse after a reload on expiry |

## Verification
A tick and a register write can land in the same cycle.

The bench provokes this case twice:

1. It runs an enabled counter down to zero, then presents a tick together with a reload write.
2. It runs an enabled counter down to zero again, then presents a tick together with a self-clear write.

In both cases the bench requires that no expiry pulse appears. It then reads the count back and requires the written value in the first case and zero in the second.

A read of the count that coincides with a decrementing tick is judged in the same way. The bench requires that the response carries the value from before the tick and that a second read shows the decremented value.

// File: rtl/rtick_pkg.sv
package rtick_pkg;
  localparam int DATA_W   = 32;
  localparam int RELOAD_W = 16;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_RELOAD = 8'h08;
  localparam logic [7:0] OFS_VALUE  = 8'h0C;

  localparam int CTRL_SRST_BIT = 31;
  localparam int CTRL_RUN_BIT  = 0;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_VALUE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rtick_decode.sv
module rtick_decode
  import rtick_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output reg_sel_e          sel,
  output logic              wr_ctrl,
  output logic              wr_reload
);
  logic word_ok;

  // Only full-word requests reach a register (R2).
  assign word_ok = req_valid && (req_size == SIZE_WORD);

  always_comb begin
    sel = SEL_NONE;
    if (word_ok) begin
      if (req_addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
      else if (req_addr == ADDR_W'(OFS_RELOAD)) sel = SEL_RELOAD;
      else if (req_addr == ADDR_W'(OFS_VALUE))  sel = SEL_VALUE;
    end
  end

  // The count register has no write strobe: writes to it fall away (R8).
  assign wr_ctrl   = req_write && (sel == SEL_CTRL);
  assign wr_reload = req_write && (sel == SEL_RELOAD);
endmodule

// File: rtl/rtick_regs.sv
module rtick_regs
  import rtick_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic                wr_reload,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   ctrl_q,
  output logic [RELOAD_W-1:0] reload_q,
  output logic                soft_clr,
  output logic                load_now,
  output logic                run_en
);
  assign soft_clr = wr_ctrl && wdata[CTRL_SRST_BIT];
  assign load_now = wr_reload;
  assign run_en   = ctrl_q[CTRL_RUN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (soft_clr) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= wdata;
      if (wr_reload) reload_q <= wdata[RELOAD_W-1:0];
    end
  end

  a_r5_clear_regs: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (ctrl_q == '0) && (reload_q == '0));

  a_r4_store_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[CTRL_SRST_BIT]) |=> ctrl_q == $past(wdata));

  a_r2_quiet_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && !wr_reload) |=> $stable(ctrl_q) && $stable(reload_q));
endmodule

// File: rtl/rtick_counter.sv
module rtick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expired
);
  logic step;
  logic at_zero;

  assign at_zero = (count == '0);
  // Register writes take precedence over a tick (R11).
  assign step    = run_en && tick && !clr && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (clr) begin
        count <= '0;
      end else if (load) begin
        count <= load_val;
      end else if (step) begin
        if (at_zero) begin
          count   <= reload_val;
          expired <= 1'b1;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr && !load) |=> $stable(count));

  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && !clr && !load && count != '0) |=> count == $past(count) - CNT_W'(1));

  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(run_en && tick && !clr && !load && count == '0));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> count == $past(load_val));

  a_r11_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (clr || load) |=> !expired);
endmodule

// File: rtl/rtick_timer.sv
module rtick_timer
  import rtick_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
  ,
  output logic              expired
);
  localparam int PAD_W = DATA_W - RELOAD_W;

  reg_sel_e            sel;
  logic                wr_ctrl, wr_reload;
  logic [DATA_W-1:0]   ctrl_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] count;
  logic                soft_clr, load_now, run_en;
  logic [DATA_W-1:0]   rd_mux;

  rtick_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .sel       (sel),
    .wr_ctrl   (wr_ctrl),
    .wr_reload (wr_reload)
  );

  rtick_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_reload (wr_reload),
    .wdata     (req_wdata),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .soft_clr  (soft_clr),
    .load_now  (load_now),
    .run_en    (run_en)
  );

  rtick_counter #(.CNT_W(RELOAD_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .tick       (tick_en),
    .clr        (soft_clr),
    .load       (load_now),
    .load_val   (req_wdata[RELOAD_W-1:0]),
    .reload_val (reload_q),
    .count      (count),
    .expired    (expired)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL:   rd_mux = ctrl_q;
      SEL_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_q};
      SEL_VALUE:  rd_mux = {{PAD_W{1'b0}}, count};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  a_r10_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  a_r2_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size != SIZE_WORD) |=> rsp_rdata == '0);
endmodule

// File: tb/tb_rtick_timer.sv
module tb_rtick_timer;
  localparam int OP_WR = 0, OP_RD = 1, OP_TK = 2;
  localparam int NV = 31;
  // Vector fields: req tag[7:0], op[1:0], addr[7:0], size[1:0], data[31:0], expect[31:0]
  localparam logic [83:0] VEC [0:NV-1] = '{
    {8'd1,  2'd1, 8'h00, 2'd2, 32'h0,        32'h0},
    {8'd1,  2'd1, 8'h08, 2'd2, 32'h0,        32'h0},
    {8'd1,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h0},
    {8'd3,  2'd0, 8'h08, 2'd2, 32'hABCD0003, 32'h0},
    {8'd3,  2'd1, 8'h08, 2'd2, 32'h0,        32'h3},
    {8'd3,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h3},
    {8'd7,  2'd2, 8'h00, 2'd0, 32'd3,        32'd0},
    {8'd7,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h3},
    {8'd4,  2'd0, 8'h00, 2'd2, 32'h00000101, 32'h0},
    {8'd4,  2'd1, 8'h00, 2'd2, 32'h0,        32'h101},
    {8'd6,  2'd2, 8'h00, 2'd0, 32'd3,        32'd0},
    {8'd6,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h0},
    {8'd6,  2'd2, 8'h00, 2'd0, 32'd1,        32'd1},
    {8'd6,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h3},
    {8'd6,  2'd2, 8'h00, 2'd0, 32'd4,        32'd1},
    {8'd8,  2'd0, 8'h0C, 2'd2, 32'h55,       32'h0},
    {8'd8,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h3},
    {8'd6,  2'd2, 8'h00, 2'd0, 32'd2,        32'd0},
    {8'd7,  2'd0, 8'h00, 2'd2, 32'h0,        32'h0},
    {8'd7,  2'd2, 8'h00, 2'd0, 32'd5,        32'd0},
    {8'd7,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h1},
    {8'd9,  2'd1, 8'h04, 2'd2, 32'h0,        32'h0},
    {8'd9,  2'd1, 8'h40, 2'd2, 32'h0,        32'h0},
    {8'd2,  2'd0, 8'h08, 2'd1, 32'h7,        32'h0},
    {8'd2,  2'd1, 8'h08, 2'd2, 32'h0,        32'h3},
    {8'd2,  2'd1, 8'h08, 2'd0, 32'h0,        32'h0},
    {8'd5,  2'd0, 8'h00, 2'd2, 32'h80000001, 32'h0},
    {8'd5,  2'd1, 8'h00, 2'd2, 32'h0,        32'h0},
    {8'd5,  2'd1, 8'h08, 2'd2, 32'h0,        32'h0},
    {8'd5,  2'd1, 8'h0C, 2'd2, 32'h0,        32'h0},
    {8'd5,  2'd2, 8'h00, 2'd0, 32'd2,        32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        expired;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rtick_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .expired(expired)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, let the posedge take it, sample at next negedge.
  task automatic step(input logic wr, input logic rd, input logic tk,
                      input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = wr | rd;
    req_write = wr;
    req_addr  = a;
    req_size  = sz;
    req_wdata = d;
    tick_en   = tk;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    tick_en   = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b0, 1'b0, a, 2'd2, d);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] exp);
    step(1'b0, 1'b1, 1'b0, a, sz, 32'h0);
    check({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, exp);
  endtask

  task automatic ticks(input int n, output int pulses);
    pulses = 0;
    for (int k = 0; k < n; k++) begin
      step(1'b0, 1'b0, 1'b1, 8'h0, 2'd0, 32'h0);
      if (expired) pulses++;
    end
  endtask

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs quiet after reset
    check("R1 expired", {31'd0, expired}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][83:76], i);
      case (int'(VEC[i][75:74]))
        OP_WR: step(1'b1, 1'b0, 1'b0, VEC[i][73:66], VEC[i][65:64], VEC[i][63:32]);
        OP_RD: rd_chk(tag, VEC[i][73:66], VEC[i][65:64], VEC[i][31:0]);
        OP_TK: begin
          ticks(int'(VEC[i][63:32]), p);
          check({tag, " pulses"}, 32'(p), VEC[i][31:0]);
        end
        default: ;
      endcase
    end

    // R11: reload write in the same cycle as an expiring tick
    wr32(8'h08, 32'h2);
    wr32(8'h00, 32'h1);
    ticks(2, p);
    step(1'b1, 1'b0, 1'b1, 8'h08, 2'd2, 32'h9);
    check("R11 reload+tick no pulse", {31'd0, expired}, 32'd0);
    rd_chk("R11 reload+tick count", 8'h0C, 2'd2, 32'h9);
    ticks(1, p);
    check("R11 next tick pulses", 32'(p), 32'd0);
    rd_chk("R6 after decrement", 8'h0C, 2'd2, 32'h8);

    // R11: self-clear in the same cycle as an expiring tick
    wr32(8'h08, 32'h1);
    ticks(1, p);
    step(1'b1, 1'b0, 1'b1, 8'h00, 2'd2, 32'h80000001);
    check("R11 clear+tick no pulse", {31'd0, expired}, 32'd0);
    rd_chk("R11 clear+tick count", 8'h0C, 2'd2, 32'h0);
    rd_chk("R5 ctrl after clear", 8'h00, 2'd2, 32'h0);

    // R6: zero reload expires on every tick
    wr32(8'h08, 32'h0);
    wr32(8'h00, 32'h1);
    ticks(3, p);
    check("R6 zero reload pulses", 32'(p), 32'd3);

    // R3: only the low half of the reload write is kept
    wr32(8'h08, 32'h1234FFFF);
    rd_chk("R3 reload wide", 8'h08, 2'd2, 32'h0000FFFF);
    rd_chk("R8 count wide", 8'h0C, 2'd2, 32'h0000FFFF);

    // R10: read of the count coinciding with a decrementing tick
    wr32(8'h08, 32'h5);
    step(1'b0, 1'b1, 1'b1, 8'h0C, 2'd2, 32'h0);
    check("R10 read during tick", rsp_rdata, 32'h5);
    rd_chk("R10 read after tick", 8'h0C, 2'd2, 32'h4);

    // R9: write to an undefined offset changes nothing visible
    wr32(8'h10, 32'hFFFFFFFF);
    rd_chk("R9 ctrl untouched", 8'h00, 2'd2, 32'h1);
    rd_chk("R9 reload untouched", 8'h08, 2'd2, 32'h5);

    // R1: hardware reset while running
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 ctrl after reset", 8'h00, 2'd2, 32'h0);
    rd_chk("R1 reload after reset", 8'h08, 2'd2, 32'h0);
    rd_chk("R1 count after reset", 8'h0C, 2'd2, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule